// File: doc/BRIEF.md
# Deferred Word-Conflict Resolution Buffer

This block keeps a record of each consumer thread that has read a speculatively shared line without waiting for its producers. Each record carries the line tag, the consumer's thread number, the handling mode chosen for the line, and, for value prediction, the line contents that the consumer was given. Each record also keeps a per-word mask. The mask marks the words of that line that earlier threads have since changed.

Stores from earlier threads are broadcast to every live record. Under the delay mode, any such store marks its word. Under the value-predict mode, a store marks its word only when the written data differs from the predicted word. When the consumer becomes non-speculative, a resolve request supplies the consumer's per-word load bits. A sequential search finds the record, frees it, and reports whether the consumer must be squashed. The squash is reported when any loaded word is marked. If every slot is taken, a new record cannot be made, and the requester then falls back to plain line-level speculation.

Top module: `spec_pend_buf`

## Requirements
- R1: After reset no slot is live, and `rs_busy`, `rs_done` and `alloc_done` are low.
- R2: An allocation request is answered by `alloc_done` exactly one cycle later. It takes the lowest-numbered free slot and reports `alloc_ok`=1. When all slots are live, it reports `alloc_ok`=0 and no slot changes.
- R3: In delay mode (`alloc_vpred`=0), a store whose tag matches, and whose `st_tid` is numerically smaller than the record's thread number, sets mask bit `st_word`. Bit w of every mask and of `rs_load` stands for word w.
- R4: In value-predict mode (`alloc_vpred`=1), a matching earlier store sets bit w only when `st_data` differs from predicted word w, which is taken from `alloc_line[w*32 +: 32]`. Set bits stay set until the record is freed.
- R5: A store to a different tag has no effect on a record. So does a store whose `st_tid` is equal to or greater than the record's thread number.
- R6: A resolve that finds the record with the same tag and thread number reports `rs_hit`=1 and returns that thread number on `rs_tid_out`. It reports `rs_squash`=1 exactly when `rs_load` AND the mask is non-zero.
- R7: A successful resolve frees its slot, so a repeat of the same request misses.
- R8: A resolve that finds no matching record reports `rs_hit`=0 and `rs_squash`=0.
- R9: An accepted resolve raises `rs_busy` on the next cycle. Requests made while busy are ignored. `rs_done` pulses for one cycle as `rs_busy` falls.
- R10: The search steps over a free slot in one cycle and spends SCAN_CYC cycles on each live slot. A match at slot 0 completes SCAN_CYC cycles after acceptance, a miss on an empty buffer completes ENTRIES cycles after acceptance, and no search lasts more than ENTRIES*SCAN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Create a record |
| alloc_tag | input | 20 | Line tag of the new record |
| alloc_tid | input | 6 | Consumer thread number |
| alloc_vpred | input | 1 | 1 = value-predict mode, 0 = delay mode |
| alloc_line | input | 128 | Line value given to the consumer |
| alloc_done | output | 1 | Allocation answered |
| alloc_ok | output | 1 | Allocation succeeded |
| st_valid | input | 1 | Predecessor store broadcast |
| st_tag | input | 20 | Store line tag |
| st_tid | input | 6 | Storing thread number |
| st_word | input | 2 | Word index within the line |
| st_data | input | 32 | Stored word value |
| rs_valid | input | 1 | Resolve request |
| rs_tag | input | 20 | Tag to resolve |
| rs_tid | input | 6 | Consumer to resolve |
| rs_load | input | 4 | Consumer's per-word load bits |
| rs_busy | output | 1 | Search in progress |
| rs_done | output | 1 | Resolve result valid (one cycle) |
| rs_hit | output | 1 | Record was found |
| rs_squash | output | 1 | Consumer must be squashed |
| rs_tid_out | output | 6 | Thread number of the resolved record |

## Verification
Directed cases target the following corner cases:
- The word-overlap boundary, using the load bits 0010 against masks 1000 and 1010. A wrong overlap test shows up as a missed squash or a spurious squash.
- A value-predict store of the predicted value versus a different value. A design that ignores the predicted value squashes consumers that were given correct data.
- Stores from later threads and from other lines, which a loose filter would wrongly let mark the mask.
- The full buffer with one slot too many, and the reuse of a freed slot. Both expose a bad free-slot choice.
- The exact search latency, for a hit at slot 0 and for a miss on an empty buffer.
- A second request made while busy, which must not produce a second result.

Random traffic over a few tags and threads is compared against a bench model of the slots.

// File: rtl/spb_pkg.sv
package spb_pkg;
    parameter int TAG_W  = 20;
    parameter int TID_W  = 6;
    parameter int WORDS  = 4;
    parameter int DATA_W = 32;
    localparam int WIDX_W = $clog2(WORDS);

    typedef enum logic { MODE_DELAY = 1'b0, MODE_VPRED = 1'b1 } mech_e;

    typedef logic [WORDS-1:0]             wmask_t;
    typedef logic [WORDS-1:0][DATA_W-1:0] line_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [TID_W-1:0] tid;
        mech_e            mode;
        wmask_t           mask;
        line_t            pred;
    } pend_ent_t;

    // a predecessor store marks its word unless it re-wrote the predicted data
    function automatic logic word_dirty(mech_e m, logic [DATA_W-1:0] pred,
                                        logic [DATA_W-1:0] wr);
        return (m == MODE_DELAY) || (pred != wr);
    endfunction

    function automatic logic words_overlap(wmask_t ld, wmask_t m);
        return |(ld & m);
    endfunction
endpackage

// File: rtl/spb_slot.sv
module spb_slot import spb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TID_W-1:0]  wr_tid,
    input  mech_e             wr_mode,
    input  line_t             wr_pred,
    input  logic              st_en,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic [TID_W-1:0]  st_tid,
    input  logic [WIDX_W-1:0] st_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic              clr_en,
    output pend_ent_t         ent
);
    logic st_hit;
    assign st_hit = st_en && ent.valid && (ent.tag == st_tag) && (st_tid < ent.tid)
                    && word_dirty(ent.mode, ent.pred[st_word], st_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (clr_en) begin
            ent.valid <= 1'b0;
        end else if (wr_en) begin
            ent.valid <= 1'b1;
            ent.tag   <= wr_tag;
            ent.tid   <= wr_tid;
            ent.mode  <= wr_mode;
            ent.mask  <= '0;
            ent.pred  <= wr_pred;
        end else if (st_hit) begin
            ent.mask[st_word] <= 1'b1;
        end
    end
endmodule

// File: rtl/spb_pick.sv
module spb_pick #(
    parameter int N = 128,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     used,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/spb_scan.sv
module spb_scan import spb_pkg::*; #(
    parameter int N        = 128,
    parameter int SCAN_CYC = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(SCAN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TID_W-1:0] req_tid,
    input  wmask_t           req_load,
    input  pend_ent_t        ents [N],
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             done,
    output logic             hit,
    output logic             squash,
    output logic [TID_W-1:0] tid_out
);
    typedef enum logic { S_IDLE, S_WALK } scan_st_e;
    scan_st_e         st;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] dwell;
    logic [TAG_W-1:0] q_tag;
    logic [TID_W-1:0] q_tid;
    wmask_t           q_load;
    pend_ent_t        cur;
    logic             match, last_dwell, at_end;

    assign cur        = ents[idx];
    assign match      = cur.valid && (cur.tag == q_tag) && (cur.tid == q_tid);
    assign last_dwell = (dwell == CNT_W'(SCAN_CYC - 1));
    assign at_end     = (idx == IDX_W'(N - 1));
    assign busy       = (st == S_WALK);
    assign clr_en     = busy && cur.valid && last_dwell && match;
    assign clr_idx    = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; idx <= '0; dwell <= '0;
            q_tag <= '0; q_tid <= '0; q_load <= '0;
            done <= 1'b0; hit <= 1'b0; squash <= 1'b0; tid_out <= '0;
        end else begin
            done <= 1'b0;
            if (st == S_IDLE) begin
                if (req_valid) begin
                    q_tag <= req_tag; q_tid <= req_tid; q_load <= req_load;
                    idx <= '0; dwell <= '0; st <= S_WALK;
                end
            end else if (cur.valid && !last_dwell) begin
                dwell <= dwell + 1'b1;
            end else if (cur.valid && match) begin
                st <= S_IDLE; done <= 1'b1; hit <= 1'b1;
                squash  <= words_overlap(q_load, cur.mask);
                tid_out <= q_tid;
            end else begin
                dwell <= '0;
                if (at_end) begin
                    st <= S_IDLE; done <= 1'b1; hit <= 1'b0; squash <= 1'b0;
                    tid_out <= q_tid;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_pend_buf.sv
module spec_pend_buf import spb_pkg::*; #(
    parameter int ENTRIES  = 128,
    parameter int SCAN_CYC = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_valid,
    input  logic [TAG_W-1:0]        alloc_tag,
    input  logic [TID_W-1:0]        alloc_tid,
    input  logic                    alloc_vpred,
    input  logic [WORDS*DATA_W-1:0] alloc_line,
    output logic                    alloc_done,
    output logic                    alloc_ok,
    input  logic                    st_valid,
    input  logic [TAG_W-1:0]        st_tag,
    input  logic [TID_W-1:0]        st_tid,
    input  logic [WIDX_W-1:0]       st_word,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    rs_valid,
    input  logic [TAG_W-1:0]        rs_tag,
    input  logic [TID_W-1:0]        rs_tid,
    input  logic [WORDS-1:0]        rs_load,
    output logic                    rs_busy,
    output logic                    rs_done,
    output logic                    rs_hit,
    output logic                    rs_squash,
    output logic [TID_W-1:0]        rs_tid_out
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    pend_ent_t        ents [ENTRIES];
    logic [ENTRIES-1:0] used;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    mech_e            new_mode;
    line_t            new_line;

    assign new_mode = alloc_vpred ? MODE_VPRED : MODE_DELAY;
    assign new_line = alloc_line;

    spb_pick #(.N(ENTRIES)) u_pick (
        .used(used), .any_free(any_free), .idx(free_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign used[g] = ents[g].valid;
        spb_slot u_slot (
            .clk(clk), .rst(rst),
            .wr_en(alloc_valid && any_free && (free_idx == IDX_W'(g))),
            .wr_tag(alloc_tag), .wr_tid(alloc_tid), .wr_mode(new_mode), .wr_pred(new_line),
            .st_en(st_valid), .st_tag(st_tag), .st_tid(st_tid),
            .st_word(st_word), .st_data(st_data),
            .clr_en(clr_en && (clr_idx == IDX_W'(g))),
            .ent(ents[g])
        );
    end

    spb_scan #(.N(ENTRIES), .SCAN_CYC(SCAN_CYC)) u_scan (
        .clk(clk), .rst(rst),
        .req_valid(rs_valid), .req_tag(rs_tag), .req_tid(rs_tid), .req_load(rs_load),
        .ents(ents), .busy(rs_busy), .clr_en(clr_en), .clr_idx(clr_idx),
        .done(rs_done), .hit(rs_hit), .squash(rs_squash), .tid_out(rs_tid_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_done <= 1'b0;
            alloc_ok   <= 1'b0;
        end else begin
            alloc_done <= alloc_valid;
            alloc_ok   <= alloc_valid && any_free;
        end
    end
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
    parameter int ENTRIES  = 128,
    parameter int SCAN_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic alloc_valid,
    input logic alloc_done,
    input logic alloc_ok,
    input logic rs_valid,
    input logic rs_busy,
    input logic rs_done,
    input logic rs_hit,
    input logic rs_squash
);
    logic [31:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !rs_busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    // R2
    alloc_answer_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> alloc_done);
    // R2
    alloc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !alloc_valid |=> !alloc_done && !alloc_ok);
    // R8
    miss_no_squash_chk: assert property (@(posedge clk) disable iff (rst)
        rs_done && !rs_hit |-> !rs_squash);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rs_valid && !rs_busy |=> rs_busy);
    // R9
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rs_busy) |-> rs_done);
    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rs_done |-> !rs_busy && $past(rs_busy));
    // R10
    scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= 32'(ENTRIES * SCAN_CYC));
endmodule

bind spec_pend_buf spb_chk #(.ENTRIES(ENTRIES), .SCAN_CYC(SCAN_CYC)) u_spb_chk (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_done(alloc_done),
    .alloc_ok(alloc_ok), .rs_valid(rs_valid), .rs_busy(rs_busy), .rs_done(rs_done),
    .rs_hit(rs_hit), .rs_squash(rs_squash)
);

// File: tb/spec_pend_buf_bench.sv
module spec_pend_buf_bench;
    import spb_pkg::*;
    localparam int N  = 128;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                    alloc_valid = 0, alloc_vpred = 0;
    logic [TAG_W-1:0]        alloc_tag = 0;
    logic [TID_W-1:0]        alloc_tid = 0;
    logic [WORDS*DATA_W-1:0] alloc_line = 0;
    logic                    alloc_done, alloc_ok;
    logic                    st_valid = 0;
    logic [TAG_W-1:0]        st_tag = 0;
    logic [TID_W-1:0]        st_tid = 0;
    logic [WIDX_W-1:0]       st_word = 0;
    logic [DATA_W-1:0]       st_data = 0;
    logic                    rs_valid = 0;
    logic [TAG_W-1:0]        rs_tag = 0;
    logic [TID_W-1:0]        rs_tid = 0;
    logic [WORDS-1:0]        rs_load = 0;
    logic                    rs_busy, rs_done, rs_hit, rs_squash;
    logic [TID_W-1:0]        rs_tid_out;

    spec_pend_buf #(.ENTRIES(N), .SCAN_CYC(SC)) u_spec_pend_buf (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model of the slots
    bit               m_valid [N];
    logic [TAG_W-1:0] m_tag   [N];
    logic [TID_W-1:0] m_tid   [N];
    bit               m_vp    [N];
    logic [DATA_W-1:0] m_pred [N][WORDS];
    logic [WORDS-1:0] m_mask  [N];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [TAG_W-1:0] tag, input logic [TID_W-1:0] tid,
                            input bit vp, input logic [DATA_W-1:0] p0, input logic [DATA_W-1:0] p1,
                            input logic [DATA_W-1:0] p2, input logic [DATA_W-1:0] p3);
        int slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
        alloc_valid = 1; alloc_tag = tag; alloc_tid = tid; alloc_vpred = vp;
        alloc_line = {p3, p2, p1, p0};
        @(posedge clk); @(negedge clk);
        alloc_valid = 0;
        chk(alloc_done == 1'b1, "R2 alloc_done", alloc_done, 1);
        chk(alloc_ok == (slot >= 0), "R2 alloc_ok", alloc_ok, slot >= 0);
        if (slot >= 0) begin
            m_valid[slot] = 1; m_tag[slot] = tag; m_tid[slot] = tid; m_vp[slot] = vp;
            m_pred[slot][0] = p0; m_pred[slot][1] = p1; m_pred[slot][2] = p2; m_pred[slot][3] = p3;
            m_mask[slot] = '0;
        end
    endtask

    task automatic do_store(input logic [TAG_W-1:0] tag, input logic [TID_W-1:0] tid,
                            input int w, input logic [DATA_W-1:0] d);
        st_valid = 1; st_tag = tag; st_tid = tid; st_word = WIDX_W'(w); st_data = d;
        @(posedge clk); @(negedge clk);
        st_valid = 0;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == tag && tid < m_tid[i] && (!m_vp[i] || m_pred[i][w] != d))
                m_mask[i][w] = 1'b1;
    endtask

    task automatic do_resolve(input logic [TAG_W-1:0] tag, input logic [TID_W-1:0] tid,
                              input logic [WORDS-1:0] ld, input string req, output int lat);
        int slot = -1;
        bit exp_sq = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_valid[i] && m_tag[i] == tag && m_tid[i] == tid) slot = i;
        if (slot >= 0) exp_sq = |(ld & m_mask[slot]);
        rs_valid = 1; rs_tag = tag; rs_tid = tid; rs_load = ld;
        @(posedge clk); @(negedge clk);
        rs_valid = 0;
        lat = 0;
        while (!rs_done && lat < 2000) begin
            @(negedge clk); lat++;
        end
        chk(rs_done == 1'b1, {req, " done"}, rs_done, 1);
        chk(rs_hit == (slot >= 0), {req, " hit"}, rs_hit, slot >= 0);
        chk(rs_squash == exp_sq, {req, " squash"}, rs_squash, exp_sq);
        if (slot >= 0) begin
            chk(rs_tid_out == tid, {req, " tid"}, rs_tid_out, tid);
            m_valid[slot] = 0;
        end
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        process::self().srandom(32'd2024);
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_mask[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1
        chk(!rs_busy && !rs_done && !alloc_done, "R1 reset outputs", {rs_busy, rs_done, alloc_done}, 0);

        // R10 miss on empty buffer, R8
        do_resolve(20'h111, 6'd9, 4'b1111, "R8 empty miss", lat);
        chk(lat == N, "R10 empty latency", lat, N);

        // R3 R6 delay: mask 1000 vs load 0010 -> no squash; R10 slot-0 latency
        do_alloc(20'hA0, 6'd10, 0, 0, 0, 0, 0);
        do_store(20'hA0, 6'd4, 3, 32'h5);
        do_resolve(20'hA0, 6'd10, 4'b0010, "R6 R3 no-overlap", lat);
        chk(lat == SC, "R10 hit latency", lat, SC);
        // R3 R6 mask 1010 -> squash
        do_alloc(20'hA0, 6'd10, 0, 0, 0, 0, 0);
        do_store(20'hA0, 6'd4, 3, 32'h5);
        do_store(20'hA0, 6'd5, 1, 32'h7);
        do_resolve(20'hA0, 6'd10, 4'b0010, "R6 R3 overlap", lat);
        chk(rs_squash == 1'b1, "R3 squash expected", rs_squash, 1);

        // R4 value predict: same value -> clear, different -> squash
        do_alloc(20'hB0, 6'd20, 1, 0, 25, 0, 0);
        do_store(20'hB0, 6'd3, 1, 25);
        do_resolve(20'hB0, 6'd20, 4'b0010, "R4 same value", lat);
        chk(rs_squash == 1'b0, "R4 no squash", rs_squash, 0);
        do_alloc(20'hB0, 6'd20, 1, 0, 25, 0, 0);
        do_store(20'hB0, 6'd3, 1, 26);
        do_store(20'hB0, 6'd3, 1, 25);
        do_resolve(20'hB0, 6'd20, 4'b0010, "R4 diff value sticky", lat);
        chk(rs_squash == 1'b1, "R4 squash", rs_squash, 1);

        // R5 later thread, equal thread, other tag ignored
        do_alloc(20'hC0, 6'd12, 0, 0, 0, 0, 0);
        do_store(20'hC0, 6'd13, 0, 1);
        do_store(20'hC0, 6'd12, 0, 1);
        do_store(20'hC1, 6'd1, 0, 1);
        do_resolve(20'hC0, 6'd12, 4'b1111, "R5 ignored stores", lat);
        chk(rs_squash == 1'b0, "R5 no squash", rs_squash, 0);

        // R7 freed entry misses on repeat
        do_alloc(20'hD0, 6'd30, 0, 0, 0, 0, 0);
        do_resolve(20'hD0, 6'd30, 4'b0001, "R7 first", lat);
        do_resolve(20'hD0, 6'd30, 4'b0001, "R7 repeat", lat);
        chk(rs_hit == 1'b0, "R7 freed", rs_hit, 0);

        // R9 request while busy ignored
        do_alloc(20'hE0, 6'd7, 0, 0, 0, 0, 0);
        rs_valid = 1; rs_tag = 20'hE0; rs_tid = 6'd7; rs_load = 4'b0001;
        @(posedge clk); @(negedge clk);
        chk(rs_busy == 1'b1, "R9 busy", rs_busy, 1);
        rs_tag = 20'hFFF; rs_tid = 6'd1;
        @(posedge clk); @(negedge clk);
        rs_valid = 0;
        lat = 0;
        while (!rs_done && lat < 2000) begin @(negedge clk); lat++; end
        chk(rs_hit && rs_tid_out == 6'd7, "R9 first request served", rs_tid_out, 7);
        m_valid[0] = 0;
        begin
            bit extra = 0;
            repeat (6) begin @(negedge clk); if (rs_done || rs_busy) extra = 1; end
            chk(!extra, "R9 busy request ignored", extra, 0);
        end

        // R2 full buffer
        for (int i = 0; i < N; i++) do_alloc(20'h300 + 20'(i), 6'd40, 0, 0, 0, 0, 0);
        do_alloc(20'h999, 6'd41, 0, 0, 0, 0, 0);
        chk(alloc_ok == 1'b0, "R2 full fails", alloc_ok, 0);
        do_resolve(20'h300 + 20'd5, 6'd40, 4'b0001, "R7 free one", lat);
        do_alloc(20'h998, 6'd42, 0, 0, 0, 0, 0);
        chk(alloc_ok == 1'b1, "R2 reuse freed", alloc_ok, 1);
        do_resolve(20'h998, 6'd42, 4'b0001, "R2 reused slot", lat);
        for (int i = 0; i < N; i++)
            if (m_valid[i]) do_resolve(m_tag[i], m_tid[i], 4'b0000, "R7 drain", lat);

        // random traffic
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 9);
            logic [TAG_W-1:0] t = TAG_W'($urandom_range(0, 3));
            logic [TID_W-1:0] d = TID_W'($urandom_range(0, 15));
            if (op < 3) begin
                do_alloc(t, d, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                         $urandom_range(0, 3), $urandom_range(0, 3));
            end else if (op < 7) begin
                do_store(t, d, $urandom_range(0, WORDS - 1), $urandom_range(0, 3));
            end else begin
                int pick = -1;
                for (int i = 0; i < N; i++) if (m_valid[i] && $urandom_range(0, 3) == 0) pick = i;
                if (pick >= 0) begin t = m_tag[pick]; d = m_tid[pick]; end
                do_resolve(t, d, WORDS'($urandom_range(0, 15)), "R6 random", lat);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule